// File: doc/BRIEF.md
# Fully Associative First-Level Address Translation Cache

This block is a small translation cache placed in front of one fetch or load/store port of a processor. Each lookup presents a virtual address, the current address space identifier and the access type (write or read, privileged or user). Every stored entry is compared at once. On a hit the physical address and memory attributes come back combinationally in the same cycle, together with the outcome of a permission check. A failed check raises a prefetch abort on an instruction-side instance and a data abort on a data-side instance. The side is chosen by a parameter.

On a miss the block takes the request, raises a refill request to a shared second-level translation cache and stalls new lookups. When the refill response arrives, the translation is written into a victim slot. In the following cycle the held request is replayed, and its result appears on the normal result outputs. Entries map pages of four sizes and are either global or tied to one address space identifier. Software maintenance can clear every entry at once, or only the non-global entries of one identifier.

Top module: `utlb`

## Requirements
- R1: The block holds ENTRIES (default 32) entries, all compared in parallel. A lookup accepted while `lk_ready` is high and that hits raises `res_valid` in the same cycle, with no clock edge in between.
- R2: `rsp_size` encodes the page size as 0 for 4KB, 1 for 64KB, 2 for 1MB and 3 for 16MB. `res_paddr` takes the stored frame bits above the page boundary and the virtual address bits below it.
- R3: An entry with its global flag clear hits only when its stored identifier equals `lk_asid`. A global entry hits for any identifier.
- R4: `dac` holds two bits per domain, at bits [2d+1:2d] for domain d: 00 or 10 means no access (always fault), 01 means check the access bits, 11 means no access-bit check. The access bits are: 00 faults always, 01 faults for user access, 10 faults for a user write, 11 never faults.
- R5: A permission fault on a hit sets `pf_abort` when IS_INSTR=1 and `dt_abort` when IS_INSTR=0. The other abort output stays low. The execute-never bit (`rsp_xn`) faults only on the instruction side, in any domain mode.
- R6: A miss gives no result. From the next cycle `refill_req` is high and `lk_ready` is low, with the request address and identifier on `refill_vaddr` and `refill_asid`. Lookups presented during this time are ignored.
- R7: When `rsp_valid` is high while `refill_req` is high, the translation is written. In the next cycle the held request is replayed and its result appears on `res_valid`/`res_paddr`, with `lk_ready` still low. `lk_ready` returns in the cycle after the replay.
- R8: A refill writes the lowest-numbered invalid slot. When every slot is valid, it replaces the slot under a round-robin pointer, which then advances by one.
- R9: `inv_all` clears every entry from the next cycle on.
- R10: `inv_asid_valid` clears only the non-global entries whose identifier equals `inv_asid`. A lookup in the same cycle still sees the entries as they were before the clear.
- R11: After reset no entry is valid, `lk_ready` is high, and `refill_req` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address space identifier |
| lk_write | input | 1 | Access is a write |
| lk_priv | input | 1 | Access is privileged |
| lk_ready | output | 1 | Block accepts lookups |
| res_valid | output | 1 | Hit result valid (including faulting hits) |
| res_paddr | output | 32 | Physical address |
| res_attr | output | 4 | Memory attributes of the hit entry |
| pf_abort | output | 1 | Prefetch abort (instruction side) |
| dt_abort | output | 1 | Data abort (data side) |
| dac | input | 32 | Per-domain access mode, two bits per domain |
| refill_req | output | 1 | Refill request to the second level |
| refill_vaddr | output | 32 | Address being refilled |
| refill_asid | output | 8 | Identifier being refilled |
| rsp_valid | input | 1 | Refill response |
| rsp_ppn | input | 20 | Physical frame number (4KB units) |
| rsp_size | input | 2 | Page size code |
| rsp_global | input | 1 | Entry is global |
| rsp_domain | input | 4 | Domain number |
| rsp_ap | input | 2 | Access bits |
| rsp_xn | input | 1 | Execute-never |
| rsp_attr | input | 4 | Memory attributes |
| inv_all | input | 1 | Clear every entry |
| inv_asid_valid | input | 1 | Clear non-global entries of one identifier |
| inv_asid | input | 8 | Identifier to clear |

## Verification
The collision that matters most is an identifier-selective clear in the same cycle as a lookup that hits a non-global entry of that identifier. The bench drives both in one cycle and expects a full hit with the old physical address. In the following cycle the same lookup must miss and raise a refill. Over the same window, the global entry and the entry of another identifier must keep hitting. A second case is a lookup presented while a refill is outstanding. It must produce no result, and the replay that follows must return the held address and not the stray one.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 12;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int ASID_W = 8;
    localparam int ATTR_W = 4;
    localparam int DOM_W  = 4;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_REPLAY = 2'd2
    } ufsm_e;

    typedef struct packed {
        logic               vld;
        logic [VPN_W-1:0]   vpn;
        logic [VPN_W-1:0]   ppn;
        pg_size_e           size;
        logic               glob;
        logic [ASID_W-1:0]  asid;
        logic [DOM_W-1:0]   dom;
        logic [1:0]         ap;
        logic               xn;
        logic [ATTR_W-1:0]  attr;
    } tlb_ent_t;

    // bits of the page number that take part in the compare
    function automatic logic [VPN_W-1:0] pg_mask(input pg_size_e sz);
        case (sz)
            PG_4K:   pg_mask = {VPN_W{1'b1}};
            PG_64K:  pg_mask = {{(VPN_W-4){1'b1}}, 4'h0};
            PG_1M:   pg_mask = {{(VPN_W-8){1'b1}}, 8'h00};
            default: pg_mask = {{(VPN_W-12){1'b1}}, 12'h000};
        endcase
    endfunction
endpackage

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]       va_vpn,
    input  logic [ASID_W-1:0]      asid,
    output logic [ENTRIES-1:0]     hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] m;
        logic             tag_eq;
        logic             asid_ok;
        always_comb begin
            m       = pg_mask(ents[g].size);
            tag_eq  = ((ents[g].vpn ^ va_vpn) & m) == '0;
            asid_ok = ents[g].glob | (ents[g].asid == asid);
            hit_vec[g] = ents[g].vld & tag_eq & asid_ok;
        end
    end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               all_full
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        all_full = !free_any;
        victim   = free_any ? free_idx : rr_ptr;
    end
endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
    import utlb_pkg::*;
#(
    parameter bit IS_INSTR = 1'b0
) (
    input  logic [31:0]      dac,
    input  logic [DOM_W-1:0] dom,
    input  logic [1:0]       ap,
    input  logic             xn,
    input  logic             write,
    input  logic             priv,
    output logic             fault
);
    logic [1:0] mode;
    logic       ap_fault;
    logic       xn_fault;

    if (IS_INSTR) begin : g_ifetch
        assign xn_fault = xn;
    end else begin : g_data
        assign xn_fault = 1'b0;
    end

    always_comb begin
        mode = dac[{dom, 1'b0} +: 2];
        case (ap)
            2'b00:   ap_fault = 1'b1;
            2'b01:   ap_fault = !priv;
            2'b10:   ap_fault = !priv && write;
            default: ap_fault = 1'b0;
        endcase
        case (mode)
            2'b01:   fault = ap_fault | xn_fault;
            2'b11:   fault = xn_fault;
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/utlb.sv
module utlb
    import utlb_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter bit IS_INSTR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              lk_priv,
    output logic              lk_ready,
    output logic              res_valid,
    output logic [VA_W-1:0]   res_paddr,
    output logic [ATTR_W-1:0] res_attr,
    output logic              pf_abort,
    output logic              dt_abort,
    input  logic [31:0]       dac,
    output logic              refill_req,
    output logic [VA_W-1:0]   refill_vaddr,
    output logic [ASID_W-1:0] refill_asid,
    input  logic              rsp_valid,
    input  logic [VPN_W-1:0]  rsp_ppn,
    input  logic [1:0]        rsp_size,
    input  logic              rsp_global,
    input  logic [DOM_W-1:0]  rsp_domain,
    input  logic [1:0]        rsp_ap,
    input  logic              rsp_xn,
    input  logic [ATTR_W-1:0] rsp_attr,
    input  logic              inv_all,
    input  logic              inv_asid_valid,
    input  logic [ASID_W-1:0] inv_asid
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        ufsm_e             st;
        logic [VA_W-1:0]   va;
        logic [ASID_W-1:0] asid;
        logic              wr;
        logic              pv;
        logic [IDX_W-1:0]  rr;
    } ctl_t;

    ctl_t                  ctl_d, ctl_q;
    tlb_ent_t [ENTRIES-1:0] ents_d, ents_q;

    logic                  replay;
    logic                  active;
    logic [VA_W-1:0]       cur_va;
    logic [ASID_W-1:0]     cur_asid;
    logic                  cur_wr;
    logic                  cur_pv;
    logic [ENTRIES-1:0]    hit_vec;
    logic [ENTRIES-1:0]    vld_vec;
    logic                  hit;
    tlb_ent_t              sel;
    logic [VPN_W-1:0]      sel_mask;
    logic                  fault;
    logic [IDX_W-1:0]      victim;
    logic                  all_full;
    tlb_ent_t              new_ent;

    // request source: live port or held request during replay
    always_comb begin
        replay   = ctl_q.st == ST_REPLAY;
        active   = replay || (ctl_q.st == ST_IDLE && lk_valid);
        cur_va   = replay ? ctl_q.va   : lk_vaddr;
        cur_asid = replay ? ctl_q.asid : lk_asid;
        cur_wr   = replay ? ctl_q.wr   : lk_write;
        cur_pv   = replay ? ctl_q.pv   : lk_priv;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign vld_vec[g] = ents_q[g].vld;
    end

    utlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ents_q),
        .va_vpn  (cur_va[VA_W-1:PG_LSB]),
        .asid    (cur_asid),
        .hit_vec (hit_vec)
    );

    utlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .vld_vec  (vld_vec),
        .rr_ptr   (ctl_q.rr),
        .victim   (victim),
        .all_full (all_full)
    );

    // one-hot select of the hitting entry
    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel = sel | (hit_vec[i] ? ents_q[i] : '0);
        end
        hit      = |hit_vec;
        sel_mask = pg_mask(sel.size);
    end

    utlb_perm #(.IS_INSTR(IS_INSTR)) u_perm (
        .dac   (dac),
        .dom   (sel.dom),
        .ap    (sel.ap),
        .xn    (sel.xn),
        .write (cur_wr),
        .priv  (cur_pv),
        .fault (fault)
    );

    always_comb begin
        lk_ready     = ctl_q.st == ST_IDLE;
        res_valid    = active && hit;
        res_paddr    = {(sel.ppn & sel_mask) | (cur_va[VA_W-1:PG_LSB] & ~sel_mask),
                        cur_va[PG_LSB-1:0]};
        res_attr     = sel.attr;
        pf_abort     = IS_INSTR  && res_valid && fault;
        dt_abort     = !IS_INSTR && res_valid && fault;
        refill_req   = ctl_q.st == ST_PEND;
        refill_vaddr = ctl_q.va;
        refill_asid  = ctl_q.asid;
    end

    always_comb begin
        new_ent      = '0;
        new_ent.vld  = 1'b1;
        new_ent.vpn  = ctl_q.va[VA_W-1:PG_LSB];
        new_ent.ppn  = rsp_ppn;
        new_ent.size = pg_size_e'(rsp_size);
        new_ent.glob = rsp_global;
        new_ent.asid = ctl_q.asid;
        new_ent.dom  = rsp_domain;
        new_ent.ap   = rsp_ap;
        new_ent.xn   = rsp_xn;
        new_ent.attr = rsp_attr;
    end

    // next-state computation
    always_comb begin
        ctl_d  = ctl_q;
        ents_d = ents_q;

        for (int i = 0; i < ENTRIES; i++) begin
            if (inv_all || (inv_asid_valid && !ents_q[i].glob &&
                            ents_q[i].asid == inv_asid)) begin
                ents_d[i].vld = 1'b0;
            end
        end

        case (ctl_q.st)
            ST_PEND: begin
                if (rsp_valid) begin
                    ents_d[victim] = new_ent;
                    if (all_full) begin
                        ctl_d.rr = (ctl_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : ctl_q.rr + 1'b1;
                    end
                    ctl_d.st = ST_REPLAY;
                end
            end
            default: begin
                if (active) begin
                    if (hit) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.st   = ST_PEND;
                        ctl_d.va   = cur_va;
                        ctl_d.asid = cur_asid;
                        ctl_d.wr   = cur_wr;
                        ctl_d.pv   = cur_pv;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            ents_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            ents_q <= ents_d;
        end
    end
endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
    parameter int ENTRIES  = 32,
    parameter bit IS_INSTR = 1'b0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_ready,
    input logic               res_valid,
    input logic               pf_abort,
    input logic               dt_abort,
    input logic               refill_req,
    input logic [31:0]        refill_vaddr,
    input logic               rsp_valid,
    input logic               inv_all,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] vld_vec
);
    p_hit_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_abort_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_abort || dt_abort) |-> res_valid);

    p_abort_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        IS_INSTR ? !dt_abort : !pf_abort);

    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (!lk_ready && !res_valid));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !rsp_valid) |=> (refill_req && $stable(refill_vaddr)));

    p_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && rsp_valid) |=> (res_valid && !lk_ready));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !(refill_req && rsp_valid)) |=> (vld_vec == '0));
endmodule

bind utlb utlb_chk #(.ENTRIES(ENTRIES), .IS_INSTR(IS_INSTR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_ready     (lk_ready),
    .res_valid    (res_valid),
    .pf_abort     (pf_abort),
    .dt_abort     (dt_abort),
    .refill_req   (refill_req),
    .refill_vaddr (refill_vaddr),
    .rsp_valid    (rsp_valid),
    .inv_all      (inv_all),
    .hit_vec      (hit_vec),
    .vld_vec      (vld_vec)
);

// File: tb/utlb_bench.sv
module utlb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;
    localparam int NVEC = 9;

    // row: va[75:44] asid[43:36] wr[35] pv[34] pa[33:2] abort_d[1] abort_i[0]
    localparam logic [75:0] VEC [NVEC] = '{
        {32'h0000_1234, 8'h05, 1'b0, 1'b0, 32'h8000_0234, 1'b0, 1'b0},
        {32'h0000_1FF0, 8'h07, 1'b1, 1'b0, 32'hC000_0FF0, 1'b0, 1'b0},
        {32'h0002_ABCD, 8'h09, 1'b0, 1'b0, 32'h9001_ABCD, 1'b0, 1'b0},
        {32'h0002_ABCD, 8'h09, 1'b1, 1'b0, 32'h9001_ABCD, 1'b1, 1'b1},
        {32'h0002_ABCD, 8'h09, 1'b1, 1'b1, 32'h9001_ABCD, 1'b0, 1'b0},
        {32'h0034_5678, 8'h05, 1'b0, 1'b0, 32'hA054_5678, 1'b1, 1'b1},
        {32'h0034_5678, 8'h05, 1'b0, 1'b1, 32'hA054_5678, 1'b0, 1'b0},
        {32'h05AB_CDEF, 8'h03, 1'b1, 1'b0, 32'hB0AB_CDEF, 1'b0, 1'b1},
        {32'h0000_7010, 8'h01, 1'b0, 1'b1, 32'hD000_7010, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, lk_write = 1'b0, lk_priv = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [31:0] dac = 32'h0000_00D5;
    logic rsp_valid = 1'b0, rsp_global = 1'b0, rsp_xn = 1'b0;
    logic [19:0] rsp_ppn = '0;
    logic [1:0]  rsp_size = '0, rsp_ap = '0;
    logic [3:0]  rsp_domain = '0, rsp_attr = '0;
    logic inv_all = 1'b0, inv_asid_valid = 1'b0;
    logic [7:0] inv_asid = '0;

    logic lk_ready, res_valid, pf_abort, dt_abort, refill_req;
    logic [31:0] res_paddr, refill_vaddr;
    logic [3:0]  res_attr;
    logic [7:0]  refill_asid;
    logic lk_ready_i, res_valid_i, pf_abort_i, dt_abort_i, refill_req_i;
    logic [31:0] res_paddr_i, refill_vaddr_i;
    logic [3:0]  res_attr_i;
    logic [7:0]  refill_asid_i;

    int tests = 0;
    int fails = 0;

    always #(HALF) clk = ~clk;

    utlb #(.ENTRIES(32), .IS_INSTR(1'b0)) u_utlb (
        .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_asid, .lk_write, .lk_priv,
        .lk_ready, .res_valid, .res_paddr, .res_attr, .pf_abort, .dt_abort, .dac,
        .refill_req, .refill_vaddr, .refill_asid,
        .rsp_valid, .rsp_ppn, .rsp_size, .rsp_global, .rsp_domain, .rsp_ap, .rsp_xn, .rsp_attr,
        .inv_all, .inv_asid_valid, .inv_asid
    );

    utlb #(.ENTRIES(32), .IS_INSTR(1'b1)) u_utlb_i (
        .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_asid, .lk_write, .lk_priv,
        .lk_ready(lk_ready_i), .res_valid(res_valid_i), .res_paddr(res_paddr_i),
        .res_attr(res_attr_i), .pf_abort(pf_abort_i), .dt_abort(dt_abort_i), .dac,
        .refill_req(refill_req_i), .refill_vaddr(refill_vaddr_i), .refill_asid(refill_asid_i),
        .rsp_valid, .rsp_ppn, .rsp_size, .rsp_global, .rsp_domain, .rsp_ap, .rsp_xn, .rsp_attr,
        .inv_all, .inv_asid_valid, .inv_asid
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // miss, refill, replay
    task automatic fill(input string tag, input logic [31:0] va, input logic [7:0] asid,
                        input logic [19:0] ppn, input logic [1:0] sz, input logic g,
                        input logic [3:0] dom, input logic [1:0] ap, input logic xn,
                        input logic [31:0] exp_pa, input logic exp_ab);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = 1'b0; lk_priv = 1'b1;
        #(HALF);
        check({tag, " miss gives no result"}, 32'(res_valid), 32'd0);
        step();
        lk_valid = 1'b0;
        #(HALF);
        check("R6 ready low while refilling", 32'(lk_ready), 32'd0);
        check("R6 refill request raised", 32'(refill_req), 32'd1);
        check("R6 refill address", refill_vaddr, va);
        check("R6 refill asid", 32'(refill_asid), 32'(asid));
        step();
        rsp_valid = 1'b1; rsp_ppn = ppn; rsp_size = sz; rsp_global = g;
        rsp_domain = dom; rsp_ap = ap; rsp_xn = xn; rsp_attr = 4'(ppn[3:0]);
        step();
        rsp_valid = 1'b0;
        #(HALF);
        check("R7 replay result", 32'(res_valid), 32'd1);
        check("R7 ready low during replay", 32'(lk_ready), 32'd0);
        check("R7 replay abort", 32'(dt_abort), 32'(exp_ab));
        if (!exp_ab) check("R7 R2 replay address", res_paddr, exp_pa);
        step();
        check("R7 ready back", 32'(lk_ready), 32'd1);
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid,
                        input logic wr, input logic pv);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr; lk_priv = pv;
        #(HALF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        rst_n = 1'b1;
        step();
        // R11 reset state
        check("R11 ready after reset", 32'(lk_ready), 32'd1);
        check("R11 no refill after reset", 32'(refill_req), 32'd0);
        check("R11 no result after reset", 32'(res_valid), 32'd0);

        // load entries; the second one also covers R3 (other asid misses)
        fill("R11", 32'h0000_1234, 8'h05, 20'h80000, 2'd0, 1'b0, 4'd0, 2'b11, 1'b0, 32'h8000_0234, 1'b0);
        fill("R3",  32'h0000_1FF0, 8'h07, 20'hC0000, 2'd0, 1'b0, 4'd0, 2'b11, 1'b0, 32'hC000_0FF0, 1'b0);
        fill("R6",  32'h0002_ABCD, 8'h09, 20'h90010, 2'd1, 1'b1, 4'd1, 2'b10, 1'b0, 32'h9001_ABCD, 1'b0);
        fill("R6",  32'h0034_5678, 8'h05, 20'hA0500, 2'd2, 1'b0, 4'd2, 2'b01, 1'b0, 32'hA054_5678, 1'b0);
        fill("R6",  32'h05AB_CDEF, 8'h03, 20'hB0000, 2'd3, 1'b1, 4'd3, 2'b00, 1'b1, 32'hB0AB_CDEF, 1'b0);
        fill("R6",  32'h0000_7010, 8'h01, 20'hD0007, 2'd0, 1'b1, 4'd4, 2'b11, 1'b0, 32'hD000_7010, 1'b1);

        // R1 R2 R3 R4 R5: vector table, all same-cycle hits
        for (int i = 0; i < NVEC; i++) begin
            look(VEC[i][75:44], VEC[i][43:36], VEC[i][35], VEC[i][34]);
            check("R1 same-cycle hit", 32'(res_valid), 32'd1);
            check("R4 R5 data-side abort", 32'(dt_abort), 32'(VEC[i][1]));
            check("R5 data side never prefetch abort", 32'(pf_abort), 32'd0);
            check("R5 instr-side abort", 32'(pf_abort_i), 32'(VEC[i][0]));
            check("R5 instr side never data abort", 32'(dt_abort_i), 32'd0);
            if (!VEC[i][1]) check("R2 physical address", res_paddr, VEC[i][33:2]);
            step();
            lk_valid = 1'b0;
        end

        // R10: asid clear in the same cycle as a hit on that asid
        inv_asid_valid = 1'b1; inv_asid = 8'h05;
        look(32'h0000_1234, 8'h05, 1'b0, 1'b1);
        check("R10 same-cycle lookup sees old entry", 32'(res_valid), 32'd1);
        check("R10 same-cycle address", res_paddr, 32'h8000_0234);
        step();
        inv_asid_valid = 1'b0; lk_valid = 1'b0;
        look(32'h0000_1234, 8'h07, 1'b0, 1'b1);
        check("R10 other asid kept", res_paddr, 32'hC000_0234);
        check("R10 other asid hit", 32'(res_valid), 32'd1);
        step();
        look(32'h0002_0004, 8'h05, 1'b0, 1'b1);
        check("R10 global kept", 32'(res_valid), 32'd1);
        step();
        lk_valid = 1'b0;
        fill("R10", 32'h0000_1234, 8'h05, 20'h80000, 2'd0, 1'b0, 4'd0, 2'b11, 1'b0, 32'h8000_0234, 1'b0);

        // R6: lookups during an outstanding refill are ignored
        look(32'h0600_0040, 8'h01, 1'b0, 1'b1);
        check("R6 miss", 32'(res_valid), 32'd0);
        step();
        look(32'h0002_ABCD, 8'h09, 1'b0, 1'b1);
        check("R6 stalled lookup gives no result", 32'(res_valid), 32'd0);
        check("R6 stalled ready", 32'(lk_ready), 32'd0);
        step();
        lk_valid = 1'b0;
        rsp_valid = 1'b1; rsp_ppn = 20'h0E000; rsp_size = 2'd0; rsp_global = 1'b1;
        rsp_domain = 4'd0; rsp_ap = 2'b11; rsp_xn = 1'b0;
        step();
        rsp_valid = 1'b0;
        #(HALF);
        check("R7 replay uses held request", res_paddr, 32'h0E00_0040);
        step();

        // R9: invalidate all
        inv_all = 1'b1;
        step();
        inv_all = 1'b0;
        fill("R9", 32'h0002_ABCD, 8'h09, 20'h90010, 2'd1, 1'b1, 4'd1, 2'b10, 1'b0, 32'h9001_ABCD, 1'b0);

        // R8: fill every slot, then one more
        inv_all = 1'b1;
        step();
        inv_all = 1'b0;
        for (int p = 0; p < 33; p++) begin
            fill("R8", 32'h1000_0000 + (p << 12), 8'h00, 20'h20000 + 20'(p), 2'd0, 1'b1,
                 4'd0, 2'b11, 1'b0, 32'h2000_0000 + (p << 12), 1'b0);
        end
        look(32'h1000_1000, 8'h00, 1'b0, 1'b1);
        check("R8 second slot still present", 32'(res_valid), 32'd1);
        step();
        lk_valid = 1'b0;
        fill("R8 first slot evicted", 32'h1000_0000, 8'h00, 20'h20000, 2'd0, 1'b1,
             4'd0, 2'b11, 1'b0, 32'h2000_0000, 1'b0);
        fill("R8 round-robin advanced", 32'h1000_1000, 8'h00, 20'h20001, 2'd0, 1'b1,
             4'd0, 2'b11, 1'b0, 32'h2000_1000, 1'b0);
        look(32'h1000_3000, 8'h00, 1'b0, 1'b1);
        check("R8 untouched slot", 32'(res_valid), 32'd1);
        step();
        lk_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule